// File: doc/BRIEF.md
# Ripple Bit-Slice Integer ALU

A purely combinational integer arithmetic and logic unit. The word is handled by a row of identical one-bit cells. Each cell holds an AND gate, an OR gate and a full adder, plus a fourth source called the compare tap. A two-bit selector shared by all cells chooses which of the four sources drives the cell's result bit. Carries ripple from cell to cell, and no lookahead is used.

A shared invert control complements operand B in every cell and raises the carry into cell 0. The adder then forms A minus B, so subtraction uses no separate subtractor. Set-on-less-than is built inside the row. The raw sign bit of the top cell's adder output is routed back to the compare tap of cell 0, and every other compare tap is tied low.

Next to the word result, the block gives a zero flag and a signed overflow flag. A three-bit operation code drives it. The code is decoded into a small control struct that the datapath consumes.

Top module: `alu_bitslice`

## Requirements
- R1: Code 3'b000 gives `result = opA & opB`.
- R2: Code 3'b001 gives `result = opA | opB`.
- R3: Code 3'b010 gives `result = (opA + opB) mod 2^32`. A carry out of bit 31 with no sign error does not raise `ovfFlag`.
- R4: Code 3'b110 gives `result = (opA - opB) mod 2^32`, formed as A plus inverted B plus one. Subtracting 0x80000000 follows the same path with no special case.
- R5: Code 3'b111 gives `result[31:1] = 0`. `result[0]` is bit 31 of the wrapped difference `opA - opB`, without any correction for overflow. As a result, `result[0]` can disagree with the true signed comparison when the subtraction overflows.
- R6: For codes whose low two bits are 2'b10, `ovfFlag` is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. This is the same as the two addends, after any inversion of B, having equal signs while the sum has the other sign. For every other code, `ovfFlag` is 0.
- R7: `zeroFlag` is 1 exactly when all 32 bits of `result` are 0, for every code.
- R8: Unlisted codes are defined. Code 3'b100 gives `opA & ~opB`. Code 3'b101 gives `opA | ~opB`. Code 3'b011 gives `{31'b0, bit 31 of (opA + opB)}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| aluOp | input | 3 | Code {invertB, select[1:0]} |
| result | output | 32 | Selected word result |
| zeroFlag | output | 1 | High when result is all zeros |
| ovfFlag | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so a wrong carry or control value shows at the ports in the same evaluation, before the next sample.

A broken carry chain or a missing carry-in shows up as a wrong sum or difference, often only in high bits. The bench therefore mixes carry-heavy patterns such as all-ones plus one and 0x80000000 operands with pseudo-random words.

A wrong wrap-around of the compare tap shows as a set bit in the wrong place, or as a comparison that was corrected for overflow. The overflowing compare cases expose that error directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } aluSel_e;

  typedef struct packed {
    logic    negB;
    aluSel_e sel;
    logic    ovfEn;
  } aluCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] aluOp,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl.negB  = aluOp[2];
    ctrl.sel   = aluSel_e'(aluOp[1:0]);
    ctrl.ovfEn = (aluOp[1:0] == 2'b10);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     cin,
  input  logic     less,
  input  aluCtrl_t ctrl,
  output logic     res,
  output logic     sum,
  output logic     cout
);
  logic bEff;

  always_comb begin
    bEff = b ^ ctrl.negB;
    sum  = a ^ bEff ^ cin;
    cout = (a & bEff) | ((a | bEff) & cin);
    unique case (ctrl.sel)
      SEL_AND: res = a & bEff;
      SEL_OR:  res = a | bEff;
      SEL_SUM: res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] lessIn;
  logic             setBit;

  assign carry[0] = ctrl.negB;
  assign setBit   = sumBits[TOP];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_wrap
      assign lessIn[i] = setBit;
    end else begin : g_tie
      assign lessIn[i] = 1'b0;
    end
    alu_slice u_slice (
      .a   (opA[i]),
      .b   (opB[i]),
      .cin (carry[i]),
      .less(lessIn[i]),
      .ctrl(ctrl),
      .res (result[i]),
      .sum (sumBits[i]),
      .cout(carry[i+1])
    );
  end

  assign zeroFlag = ~(|result);
  assign ovfFlag  = ctrl.ovfEn & (carry[TOP] ^ carry[WIDTH]);
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       aluOp,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag
);
  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .aluOp(aluOp),
    .ctrl (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .result  (result),
    .zeroFlag(zeroFlag),
    .ovfFlag (ovfFlag)
  );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       aluOp,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             ovfFlag
);
  always_comb begin
    // R1
    and_result_chk: assert (aluOp != 3'b000 || result == (opA & opB));
    // R2
    or_result_chk: assert (aluOp != 3'b001 || result == (opA | opB));
    // R5
    slt_upper_chk: assert (aluOp != 3'b111 || result[WIDTH-1:1] == '0);
    // R6
    no_overflow_chk: assert (aluOp[1:0] == 2'b10 || !ovfFlag);
    // R7
    zero_flag_chk: assert (zeroFlag == (result == '0));
    // R8
    andn_result_chk: assert (aluOp != 3'b100 || result == (opA & ~opB));
  end
endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
  .opA(opA), .opB(opB), .aluOp(aluOp),
  .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
);

// File: tb/alu_bitslice_tb.sv
module alu_bitslice_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA, opB;
  logic [2:0]  aluOp;
  logic [31:0] result;
  logic        zeroFlag, ovfFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_bitslice u_dut (
    .opA(opA), .opB(opB), .aluOp(aluOp),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, aluOp, opA, opB, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R8";
    endcase
  endfunction

  // Behavioural reference: the requested value, then the flags.
  task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] bx, expRes;
    logic [32:0] wide;
    logic        expOvf;
    @(posedge clk);
    aluOp = op; opA = a; opB = b;
    bx   = op[2] ? ~b : b;
    wide = {1'b0, a} + {1'b0, bx} + {32'd0, op[2]};
    case (op[1:0])
      2'b00: expRes = a & bx;
      2'b01: expRes = a | bx;
      2'b10: expRes = wide[31:0];
      default: expRes = {31'd0, wide[31]};
    endcase
    expOvf = (op[1:0] == 2'b10) && (a[31] == bx[31]) && (wide[31] != a[31]);
    @(negedge clk);
    check(tagOf(op), result, expRes);
    check("R6", {31'd0, ovfFlag}, {31'd0, expOvf});
    check("R7", {31'd0, zeroFlag}, {31'd0, (expRes == 32'd0)});
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [2:0]  codes [8];
    codes = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b100, 3'b101, 3'b011};
    opA = '0; opB = '0; aluOp = 3'b000;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 idle state: AND of zeros
    check("R7", {31'd0, zeroFlag}, 32'd1);
    check("R1", result, 32'd0);
    apply(3'b000, 32'hF0F0_1234, 32'h0FF0_FF00);
    apply(3'b001, 32'hF000_0001, 32'h0000_1000);
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);   // R3 carry-out, result zero, no ovf
    apply(3'b010, 32'hFFFF_FFF7, 32'hFFFF_FFF9);   // R3 -9 + -7
    apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);   // R6 positive overflow
    apply(3'b010, 32'h8000_0000, 32'h8000_0000);   // R6 negative overflow
    apply(3'b110, 32'h0000_0005, 32'h0000_0005);   // R4 zero diff
    apply(3'b110, 32'h0000_0000, 32'h8000_0000);   // R4 most negative
    apply(3'b110, 32'h8000_0000, 32'h8000_0000);   // R4
    apply(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R6 sub overflow
    apply(3'b111, 32'hFFFF_FFFE, 32'h0000_14A0);   // R5 -2 < 5280
    apply(3'b111, 32'h0000_14A0, 32'hFFFF_FFFE);   // R5
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);   // R5 overflow: raw sign 1
    apply(3'b111, 32'h8000_0000, 32'h0000_0001);   // R5 overflow: raw sign 0
    apply(3'b111, 32'h1234_5678, 32'h1234_5678);   // R5 equal
    apply(3'b100, 32'hFFFF_0000, 32'h0F0F_0F0F);   // R8
    apply(3'b101, 32'h0000_0000, 32'hFFFF_FFFF);   // R8 zero result
    apply(3'b011, 32'h7FFF_FFFF, 32'h0000_0001);   // R8
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = (i % 5 == 0) ? ra : lfsr;
      apply(codes[i % 8], ra, rb);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule